// File: doc/BRIEF.md
# Extended-Mode Parallel Port FIFO Engine

This block is the mode-controlled core of an enhanced parallel printer port. Software reaches it through a small register window. A mode register at offset 0x402 holds a 3-bit operating mode, three general flag bits and two live FIFO status bits. The block contains a 16-byte FIFO. In the FIFO printer mode, the block drains that FIFO to the peripheral by itself. It drives each byte on the data pins, waits one setup cycle, and then pulses the active-low strobe for a fixed number of clocks. It does not start the next byte until the peripheral's Busy input is low.

The mode field also selects the plain behaviours. The standard mode always drives the data pins. The byte mode lets a direction bit in the control register turn the data pins around so that the data register reads the pins. The test mode lets software push bytes into the FIFO and pop them back through the FIFO port without any pin activity, which allows it to measure the FIFO depth. The remaining mode codes are stored in the register but act as the standard mode at the pins.

Top module: `xpp_fifo_port`

## Requirements
- R1: After reset the mode is 000. The mode register reads 0x01 (empty set, full clear). `strobe_n` is high and `pd_oe` is high.
- R2: The mode register at offset 0x402 reads {mode[2:0] in bits 7:5, flags in bits 4:2, FIFO full in bit 1, FIFO empty in bit 0}. The flag bits read back as written, and bits 1:0 always show the true FIFO state.
- R3: The FIFO holds 16 bytes and returns them in first-in, first-out order. A push to a full FIFO is dropped.
- R4: In test mode (110), a read of the FIFO port (offset 0x400) when the FIFO is empty returns the last byte popped and leaves the FIFO empty.
- R5: In test mode, writes to offset 0x400 push and reads pop. `strobe_n` stays high and `pd_out` does not change.
- R6: In FIFO printer mode (010), each byte goes out in this order: the head is popped and driven on `pd_out`; one setup cycle follows; `strobe_n` is low for exactly STB_CYCLES clocks; bytes leave in FIFO order.
- R7: In FIFO printer mode, no new byte is started while `busy` is high.
- R8: Writing a mode value that differs from the current one empties the FIFO and returns the strobe engine to idle. Rewriting the same mode keeps the FIFO contents.
- R9: In standard mode (000), `pd_oe` is 1 whatever the value of control bit 5. `strobe_n` is the inverse of control bit 0 (control register at offset 0x002). The data register at offset 0x000 drives `pd_out` and reads back.
- R10: In byte mode (001) with control bit 5 set, `pd_oe` is 0 and a read of offset 0x000 returns `pd_in`. Data writes are still stored and appear on `pd_out` once bit 5 is cleared.
- R11: Modes 011, 100, 101 and 111 read back from the mode register and behave as the standard mode at the pins.
- R12: In every mode other than 010 and 110, writes to offset 0x400 are ignored.
- R13: The status register at offset 0x001 reads bit 7 = inverted `busy`, bit 6 = `ack_n`, and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 11 | Register offset from the port base |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe; pops the FIFO in test mode |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on `reg_addr` |
| pd_out | output | 8 | Value driven onto the data pins |
| pd_oe | output | 1 | Data pin output enable |
| pd_in | input | 8 | Value sensed on the data pins |
| strobe_n | output | 1 | Active-low data strobe to the peripheral |
| busy | input | 1 | Peripheral busy, high while it cannot accept data |
| ack_n | input | 1 | Peripheral acknowledge, active low |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that a strobe pulse in FIFO printer mode is not cut short by a rewrite of the same mode. The strobe-width property relies on this, and only a mode change can end a pulse early. The stimulus respects these assumptions. The peripheral model raises `busy` only after it sees the strobe fall and holds it for a fixed number of cycles. The one pulse that is interrupted on purpose is ended by a change to standard mode, so the width property does not apply to it.

// File: rtl/xpp_pkg.sv
// Shared definitions for the extended-mode parallel port.
// Assumes an 11-bit register offset space relative to the port base.
package xpp_pkg;

    localparam int REG_AW = 11;

    localparam logic [REG_AW-1:0] OFS_DATA = 11'h000;
    localparam logic [REG_AW-1:0] OFS_STAT = 11'h001;
    localparam logic [REG_AW-1:0] OFS_CTRL = 11'h002;
    localparam logic [REG_AW-1:0] OFS_FIFO = 11'h400;
    localparam logic [REG_AW-1:0] OFS_MODE = 11'h402;

    typedef enum logic [2:0] {
        MODE_STD   = 3'd0,
        MODE_BYTE  = 3'd1,
        MODE_PFIFO = 3'd2,
        MODE_EFIFO = 3'd3,
        MODE_EPP   = 3'd4,
        MODE_RSVD  = 3'd5,
        MODE_TEST  = 3'd6,
        MODE_CFG   = 3'd7
    } xmode_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SETUP = 2'd1,
        ENG_PULSE = 2'd2
    } eng_state_e;

endpackage

// File: rtl/xpp_fifo.sv
// Byte FIFO with synchronous flush.
// Pushes to a full FIFO and pops from an empty one are ignored.
// Flush has priority over push and pop in the same cycle.
module xpp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/xpp_strobe_eng.sv
// Hardware printer handshake engine.
// In idle, with the engine enabled, the FIFO not empty and busy low, it pops one byte.
// It then holds one setup cycle and drives strobe low for STB_CYCLES clocks.
// Abort or disable returns it to idle at once.
module xpp_strobe_eng
    import xpp_pkg::*;
#(
    parameter int STB_CYCLES = 4,
    parameter int W          = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         abort,
    input  logic         busy,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    output logic         pop,
    output logic [W-1:0] out_byte,
    output logic         strobe_n,
    output logic         idle
);

    localparam int CNT_W = $clog2(STB_CYCLES + 1);

    eng_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign idle     = (state_q == ENG_IDLE);
    assign pop      = enable && !abort && idle && !fifo_empty && !busy;
    assign strobe_n = (state_q != ENG_PULSE);

    // Sequence through setup and strobe pulse for each byte.
    always_ff @(posedge clk) begin
        if (!rst_n || abort || !enable) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (pop) state_q <= ENG_SETUP;
                end
                ENG_SETUP: begin
                    state_q <= ENG_PULSE;
                    cnt_q   <= '0;
                end
                ENG_PULSE: begin
                    if (cnt_q == CNT_W'(STB_CYCLES - 1)) state_q <= ENG_IDLE;
                    else                                 cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // Hold the byte on the pins from pop until the next pop.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_byte <= '0;
        else if (pop) out_byte <= fifo_head;
    end

endmodule

// File: rtl/xpp_pin_mux.sv
// Selects what the data and strobe pins show for the current mode.
// Purely combinational. Modes without their own pin behaviour fall back to standard.
module xpp_pin_mux
    import xpp_pkg::*;
#(
    parameter int W = 8
) (
    input  xmode_e       mode,
    input  logic         dir_rev,
    input  logic         ctrl_strobe,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] eng_byte,
    input  logic         eng_strobe_n,
    output logic [W-1:0] pd_out,
    output logic         pd_oe,
    output logic         strobe_n,
    output logic         read_pins
);

    assign read_pins = (mode == MODE_BYTE) && dir_rev;
    assign pd_oe     = !read_pins;
    assign pd_out    = (mode == MODE_PFIFO) ? eng_byte : latch;

    // Strobe source per mode.
    always_comb begin
        case (mode)
            MODE_PFIFO: strobe_n = eng_strobe_n;
            MODE_TEST:  strobe_n = 1'b1;
            default:    strobe_n = !ctrl_strobe;
        endcase
    end

endmodule

// File: rtl/xpp_fifo_port.sv
// Extended-mode parallel port: register decode, mode register, FIFO and handshake engine.
// Assumes one register access per cycle and inputs synchronous to clk.
// The read data is combinational on reg_addr. A test-mode FIFO read pops on the clock edge.
module xpp_fifo_port
    import xpp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int STB_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [10:0] reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [7:0]  pd_out,
    output logic        pd_oe,
    input  logic [7:0]  pd_in,
    output logic        strobe_n,
    input  logic        busy,
    input  logic        ack_n
);

    localparam int W  = 8;
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    xmode_e         mode_q;
    logic [2:0]     flags_q;
    logic [5:0]     ctrl_q;
    logic [W-1:0]   latch_q;
    logic [W-1:0]   last_q;

    logic           wr_mode;
    logic           mode_flush;
    logic           fifo_push;
    logic           test_pop;
    logic           eng_pop;
    logic           eng_idle;
    logic           eng_strobe_n;
    logic [W-1:0]   eng_byte;
    logic [W-1:0]   fifo_head;
    logic [CW-1:0]  fifo_count;
    logic           fifo_full;
    logic           fifo_empty;
    logic           read_pins;

    assign wr_mode    = reg_wr && (reg_addr == OFS_MODE);
    assign mode_flush = wr_mode && (reg_wdata[7:5] != mode_q);
    assign fifo_push  = reg_wr && (reg_addr == OFS_FIFO) &&
                        ((mode_q == MODE_PFIFO) || (mode_q == MODE_TEST));
    assign test_pop   = reg_rd && (reg_addr == OFS_FIFO) &&
                        (mode_q == MODE_TEST) && !fifo_empty;

    // Mode field and flag bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_STD;
            flags_q <= '0;
        end else if (wr_mode) begin
            mode_q  <= xmode_e'(reg_wdata[7:5]);
            flags_q <= reg_wdata[4:2];
        end
    end

    // Control and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            latch_q <= '0;
        end else begin
            if (reg_wr && (reg_addr == OFS_CTRL)) ctrl_q  <= reg_wdata[5:0];
            if (reg_wr && (reg_addr == OFS_DATA)) latch_q <= reg_wdata;
        end
    end

    // Last byte popped through the test port, returned on empty reads.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_q <= '0;
        else if (test_pop) last_q <= fifo_head;
    end

    xpp_fifo #(.DEPTH(FIFO_DEPTH), .W(W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (mode_flush),
        .push  (fifo_push),
        .wdata (reg_wdata),
        .pop   (eng_pop || test_pop),
        .head  (fifo_head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    xpp_strobe_eng #(.STB_CYCLES(STB_CYCLES), .W(W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (mode_q == MODE_PFIFO),
        .abort      (mode_flush),
        .busy       (busy),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .pop        (eng_pop),
        .out_byte   (eng_byte),
        .strobe_n   (eng_strobe_n),
        .idle       (eng_idle)
    );

    xpp_pin_mux #(.W(W)) u_mux (
        .mode         (mode_q),
        .dir_rev      (ctrl_q[5]),
        .ctrl_strobe  (ctrl_q[0]),
        .latch        (latch_q),
        .eng_byte     (eng_byte),
        .eng_strobe_n (eng_strobe_n),
        .pd_out       (pd_out),
        .pd_oe        (pd_oe),
        .strobe_n     (strobe_n),
        .read_pins    (read_pins)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DATA: reg_rdata = read_pins ? pd_in : latch_q;
            OFS_STAT: reg_rdata = {~busy, ack_n, 6'b0};
            OFS_CTRL: reg_rdata = {2'b00, ctrl_q};
            OFS_FIFO: if (mode_q == MODE_TEST) reg_rdata = fifo_empty ? last_q : fifo_head;
            OFS_MODE: reg_rdata = {mode_q, flags_q, fifo_full, fifo_empty};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/xpp_fifo_port_chk.sv
// Property checker for xpp_fifo_port, attached through bind.
// Counts strobe-low cycles itself so that the pulse-width window does not depend on $past depth.
module xpp_fifo_port_chk
    import xpp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int STB_CYCLES = 4,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode,
    input logic [2:0]    new_mode,
    input logic          reg_wr,
    input logic [10:0]   reg_addr,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic          eng_idle,
    input logic          busy,
    input logic          strobe_n,
    input logic [7:0]    pd_out,
    input logic          pd_oe,
    input logic          ctrl_dir
);

    int low_cnt;

    // Count consecutive low strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        low_cnt <= 0;
        else if (!strobe_n) low_cnt <= (low_cnt < 1000000) ? low_cnt + 1 : low_cnt;
        else               low_cnt <= 0;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(FIFO_DEPTH));

    p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    p_test_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TEST) |-> strobe_n);

    p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PFIFO) && ($past(mode) == MODE_PFIFO) && $fell(strobe_n)) |-> $stable(pd_out));

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_n) && (mode == MODE_PFIFO) && ($past(mode) == MODE_PFIFO)) |-> (low_cnt == STB_CYCLES));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PFIFO) && eng_idle && busy) |=> strobe_n);

    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == OFS_MODE) && (new_mode != mode)) |=> (fifo_empty && eng_idle));

    p_std_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_BYTE) |-> pd_oe);

    p_rev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_BYTE) && ctrl_dir) |-> !pd_oe);

endmodule

bind xpp_fifo_port xpp_fifo_port_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .STB_CYCLES (STB_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .new_mode   (reg_wdata[7:5]),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .eng_idle   (eng_idle),
    .busy       (busy),
    .strobe_n   (strobe_n),
    .pd_out     (pd_out),
    .pd_oe      (pd_oe),
    .ctrl_dir   (ctrl_q[5])
);

// File: tb/xpp_fifo_port_test.sv
`timescale 1ns/1ps
module xpp_fifo_port_test;

    localparam int DEPTH    = 16;
    localparam int PW       = 4;
    localparam int BUSY_LEN = 7;
    localparam logic [10:0] A_DATA = 11'h000, A_STAT = 11'h001, A_CTRL = 11'h002,
                            A_FIFO = 11'h400, A_MODE = 11'h402;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [10:0] reg_addr = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic [7:0]  pd_out, pd_in = '0;
    logic        pd_oe, strobe_n;
    logic        busy = 0, ack_n = 1;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    xpp_fifo_port #(.FIFO_DEPTH(DEPTH), .STB_CYCLES(PW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
        .pd_in(pd_in), .strobe_n(strobe_n), .busy(busy), .ack_n(ack_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_mode, m_low, m_st, m_cnt, m_sz;
    logic [5:0] m_ctrl;
    logic [7:0] m_data, m_last, m_byte;
    logic [7:0] q[$];
    bit         f_flush, f_epop, f_bpop, f_push;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_low = 0; m_st = 0; m_cnt = 0;
            m_ctrl = 0; m_data = 0; m_last = 0; m_byte = 0;
            q.delete();
        end else begin
            m_sz    = q.size();
            f_flush = reg_wr && reg_addr == A_MODE && int'(reg_wdata[7:5]) != m_mode;
            f_epop  = m_mode == 2 && m_st == 0 && m_sz > 0 && !busy;
            f_bpop  = reg_rd && reg_addr == A_FIFO && m_mode == 6 && m_sz > 0;
            f_push  = reg_wr && reg_addr == A_FIFO && (m_mode == 2 || m_mode == 6) && m_sz < DEPTH;
            if (f_flush) begin
                q.delete();
                m_st = 0;
            end else begin
                case (m_st)
                    0: if (f_epop) begin m_byte = q.pop_front(); m_st = 1; end
                    1: begin m_st = 2; m_cnt = 0; end
                    default: if (m_cnt == PW - 1) m_st = 0; else m_cnt++;
                endcase
                if (f_bpop) m_last = q.pop_front();
                if (f_push) q.push_back(reg_wdata);
            end
            if (reg_wr && reg_addr == A_MODE) begin
                m_mode = int'(reg_wdata[7:5]);
                m_low  = int'(reg_wdata[4:2]);
            end
            if (reg_wr && reg_addr == A_CTRL) m_ctrl = reg_wdata[5:0];
            if (reg_wr && reg_addr == A_DATA) m_data = reg_wdata;
        end
    end

    logic [7:0] e_rd, e_pd;
    logic       e_oe, e_stb;
    bit         tm_watch = 0;
    int         tm_bad = 0;
    logic [7:0] tm_pd;

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            e_oe  = !(m_mode == 1 && m_ctrl[5]);
            e_pd  = (m_mode == 2) ? m_byte : m_data;
            e_stb = (m_mode == 2) ? (m_st != 2) : (m_mode == 6) ? 1'b1 : !m_ctrl[0];
            case (reg_addr)
                A_DATA: e_rd = (m_mode == 1 && m_ctrl[5]) ? pd_in : m_data;
                A_STAT: e_rd = {~busy, ack_n, 6'b0};
                A_CTRL: e_rd = {2'b00, m_ctrl};
                A_FIFO: e_rd = (m_mode != 6) ? 8'h00 : (q.size() > 0) ? q[0] : m_last;
                A_MODE: e_rd = {3'(m_mode), 3'(m_low), q.size() == DEPTH, q.size() == 0};
                default: e_rd = 8'h00;
            endcase
            chk("R6", strobe_n, e_stb, "per-cycle strobe_n");
            chk("R6", pd_out, e_pd, "per-cycle pd_out");
            chk("R10", pd_oe, e_oe, "per-cycle pd_oe");
            chk("R2", reg_rdata, e_rd, "per-cycle reg_rdata");
            if (tm_watch && (strobe_n !== 1'b1 || pd_out !== tm_pd)) tm_bad++;
        end
    end

    // ---------------- peripheral model ----------------
    bit         resp_en = 0, prev_stb = 1;
    logic [7:0] prev_pd = '0;
    int         low_n = 0, bcnt = 0;
    logic [7:0] rx[$];

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (resp_en) begin
                if (prev_stb && !strobe_n) begin
                    chk("R7", busy, 0, "busy low when strobe falls");
                    chk("R6", pd_out, prev_pd, "data stable one cycle before strobe");
                    rx.push_back(pd_out);
                    low_n = 0;
                    bcnt  = BUSY_LEN;
                end
                if (!strobe_n) low_n++;
                if (!prev_stb && strobe_n) chk("R6", low_n, PW, "strobe pulse width");
                busy = (bcnt > 0);
                if (bcnt > 0) bcnt--;
            end
            prev_stb = strobe_n;
            prev_pd  = pd_out;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [7:0] rd;
    logic [7:0] exp_tx[$];
    int         bad;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1", strobe_n, 1, "strobe_n after reset");
        chk("R1", pd_oe, 1, "pd_oe after reset");
        bus_read(A_MODE, rd);
        chk("R1", rd, 8'h01, "mode register after reset");

        // R13 status register
        @(posedge clk); #1 busy = 1; ack_n = 0;
        bus_read(A_STAT, rd); chk("R13", rd, 8'h00, "status busy=1 ack_n=0");
        @(posedge clk); #1 busy = 0; ack_n = 1;
        bus_read(A_STAT, rd); chk("R13", rd, 8'hC0, "status busy=0 ack_n=1");
        @(posedge clk); #1 busy = 1;
        bus_read(A_STAT, rd); chk("R13", rd, 8'h40, "status busy=1 ack_n=1");
        @(posedge clk); #1 busy = 0;

        // R9 standard mode
        bus_write(A_CTRL, 8'h21);
        bus_write(A_DATA, 8'hA5);
        @(negedge clk);
        chk("R9", pd_oe, 1, "standard mode ignores direction bit");
        chk("R9", strobe_n, 0, "strobe follows inverted control bit 0");
        chk("R9", pd_out, 8'hA5, "data register on pins");
        bus_read(A_DATA, rd); chk("R9", rd, 8'hA5, "data readback");

        // R12 FIFO writes ignored outside FIFO modes
        bus_write(A_FIFO, 8'h11);
        bus_read(A_MODE, rd); chk("R12", rd, 8'h01, "FIFO still empty after write in standard mode");

        // R10 byte mode, reversed
        bus_write(A_MODE, 8'h20);
        @(posedge clk); #1 pd_in = 8'h3C;
        bus_read(A_DATA, rd); chk("R10", rd, 8'h3C, "reversed data read returns pins");
        chk("R10", pd_oe, 0, "pins released in reverse");
        bus_write(A_DATA, 8'h77);
        bus_read(A_DATA, rd); chk("R10", rd, 8'h3C, "still reads pins after write");
        bus_write(A_CTRL, 8'h01);
        @(negedge clk);
        chk("R10", pd_oe, 1, "forward after clearing bit 5");
        chk("R10", pd_out, 8'h77, "stored write appears on pins");

        // R11 other modes act as standard
        bus_write(A_CTRL, 8'h21);
        foreach (exp_tx[i]) exp_tx.delete(i);
        for (int m = 3; m <= 7; m++) begin
            if (m == 6) continue;
            bus_write(A_MODE, {3'(m), 3'b111, 2'b00});
            bus_read(A_MODE, rd);
            chk("R11", rd, {3'(m), 3'b111, 2'b01}, "mode readback");
            chk("R11", pd_oe, 1, "pins driven");
            chk("R11", strobe_n, 0, "strobe from control bit 0");
            bus_write(A_FIFO, 8'h55);
            bus_read(A_MODE, rd);
            chk("R12", rd[0], 1, "FIFO write ignored in fallback mode");
        end

        // R5, R3, R2 test mode
        bus_write(A_MODE, 8'hC0);
        @(negedge clk);
        tm_pd = pd_out;
        tm_watch = 1;
        for (int i = 0; i < 17; i++) begin
            bus_write(A_FIFO, 8'h30 + 8'(i));
            if (i == 14) begin
                bus_read(A_MODE, rd); chk("R2", rd, 8'hC0, "neither full nor empty at 15");
            end
            if (i == 15) begin
                bus_read(A_MODE, rd); chk("R2", rd, 8'hC2, "full flag at 16 entries");
            end
        end
        bus_read(A_MODE, rd); chk("R3", rd, 8'hC2, "still full after dropped push");
        for (int i = 0; i < 16; i++) begin
            bus_read(A_FIFO, rd);
            chk("R3", rd, 8'h30 + 8'(i), "FIFO order");
        end
        bus_read(A_MODE, rd); chk("R2", rd, 8'hC1, "empty after draining");
        bus_read(A_FIFO, rd); chk("R4", rd, 8'h3F, "empty read returns last value");
        bus_read(A_FIFO, rd); chk("R4", rd, 8'h3F, "repeat empty read");
        bus_read(A_MODE, rd); chk("R4", rd, 8'hC1, "empty read does not disturb FIFO");
        tm_watch = 0;
        chk("R5", tm_bad, 0, "no pin activity in test mode");

        // R8 same-mode write keeps, mode change flushes
        bus_write(A_FIFO, 8'hA0);
        bus_write(A_FIFO, 8'hA1);
        bus_write(A_MODE, 8'hC4);
        bus_read(A_MODE, rd); chk("R8", rd, 8'hC4, "same mode keeps FIFO");
        @(posedge clk); #1 busy = 1;
        bus_write(A_MODE, 8'h40);
        bus_read(A_MODE, rd); chk("R8", rd, 8'h41, "mode change flushes FIFO");

        // R7 busy held high blocks transfers
        bus_write(A_FIFO, 8'hB0);
        bus_write(A_FIFO, 8'hB1);
        bad = 0;
        repeat (20) begin @(negedge clk); if (!strobe_n) bad++; end
        chk("R7", bad, 0, "no strobe while busy high");
        bus_read(A_MODE, rd); chk("R7", rd, 8'h40, "bytes still queued");

        // R6 printer transfers with responding peripheral
        exp_tx = '{8'hB0, 8'hB1, 8'hC0, 8'h3D, 8'h00, 8'hFF, 8'h5A};
        @(posedge clk); #1 resp_en = 1;
        for (int i = 2; i < 7; i++) bus_write(A_FIFO, exp_tx[i]);
        repeat (200) @(posedge clk);
        chk("R6", rx.size(), 7, "bytes delivered");
        for (int i = 0; i < 7; i++)
            if (i < rx.size()) chk("R6", rx[i], exp_tx[i], "delivered byte order");
        bus_read(A_MODE, rd); chk("R6", rd, 8'h41, "FIFO drained");

        // R8 abort mid-pulse
        bus_write(A_CTRL, 8'h20);
        bus_write(A_FIFO, 8'h91);
        bus_write(A_FIFO, 8'h92);
        bus_write(A_FIFO, 8'h93);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!strobe_n) break;
        end
        @(posedge clk); #1 resp_en = 0;
        bus_write(A_MODE, 8'h00);
        @(negedge clk);
        chk("R8", strobe_n, 1, "strobe released on mode change");
        bus_read(A_MODE, rd); chk("R8", rd, 8'h01, "FIFO flushed mid-transfer");

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule